// File: doc/BRIEF.md
# Predicated Data-Processing Execute Unit

This unit sits in the execute stage of a simple processor core. Each cycle it receives one decoded data-processing instruction. The instruction carries a 4-bit predicate, an operation select, a set-flags bit, a first operand, and a second operand with a shift type and a shift amount. The unit checks the predicate against the current condition flags to decide whether the instruction takes effect. The second operand passes through a barrel shifter in the same cycle.

The unit produces the 32-bit result, a write enable for the result, and the next value of the four flags: negative, zero, carry and overflow. The flags live in a register inside the unit and take their new value on the following clock edge.

The flags change only when the instruction executes and its set-flags bit is high. An instruction whose predicate fails leaves every piece of state untouched.

Top module: `cexec_unit`

## Requirements
- R1: When the predicate fails, `result_we` is 0 and the flags stay unchanged. This holds even when `set_flags` is 1.
- R2: Single-flag predicates, with the flag vector ordered {N,Z,C,V} in bits 3..0:
  - code 0 executes when Z=1, code 1 when Z=0
  - code 2 executes when C=1, code 3 when C=0
  - code 4 executes when N=1, code 5 when N=0
  - code 6 executes when V=1, code 7 when V=0
- R3: Code 8 executes when C=1 and Z=0. Code 9 executes when C=0 or Z=1.
- R4: Code 10 executes when N equals V, and code 11 when N differs from V. Code 12 executes when Z=0 and N equals V. Code 13 executes when Z=1 or N differs from V.
- R5: Code 14 always executes and code 15 never executes. Whenever the instruction executes, `result_we` is 1.
- R6: The second operand is shifted before the operation by `shift_amt` bit positions (0 to 31). Shift type 0 is a logical left shift, 1 a logical right shift, 2 an arithmetic right shift and 3 a rotate right. An amount of 0 passes the operand through unchanged.
- R7: The flags register loads the new flags on the next clock edge only when the instruction executes with `set_flags`=1. Otherwise the register holds its value.
- R8: Operation 0 gives `a + b`. C is the unsigned carry out and V is the signed overflow.
- R9: Operation 1 gives `a - b`. C is 1 when no borrow occurs (a >= b unsigned), and V is the signed overflow.
- R10: Operations 2 (bitwise AND) and 3 (move the shifted operand) set C to the last bit shifted out. C keeps its old value when the amount is 0. V is left unchanged.
- R11: When the flags are updated, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R12: Reset (active-low `rst_n`) clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond | input | 4 | Predicate code |
| opsel | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 move |
| set_flags | input | 1 | Update flags when executing |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, before shift |
| shift_type | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift amount |
| exec_en | output | 1 | Predicate passed |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write enable |
| flags_next | output | 4 | Flags the register will hold after this edge, {N,Z,C,V} |
| flags_q | output | 4 | Current registered flags, {N,Z,C,V} |

## Verification
The assertions check several properties on every cycle:
- A failed predicate leaves both the write enable and the flags untouched.
- The never and always codes behave as fixed.
- The zero and GE predicates follow the registered flags.
- N and Z track the result whenever flags update.
- Logical operations keep V.
- The register loads exactly the next-flag value.

Only the bench scenarios can show the rest: the exact arithmetic results and carries for boundary operands, the carry produced by each shift type at amounts 0, 1, 4 and 31, and the full predicate table under several different flag states.

// File: rtl/cexu_pkg.sv
package cexu_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_AND = 2'd2, OP_MOV = 2'd3} alu_op_e;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} shift_e;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
endpackage

// File: rtl/cexu_cond.sv
module cexu_cond (
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       pass
);
  import cexu_pkg::*;

  function automatic logic eval_pred(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n  = f[FLG_N];
    z  = f[FLG_Z];
    cy = f[FLG_C];
    v  = f[FLG_V];
    unique case (c)
      4'd0:  eval_pred = z;
      4'd1:  eval_pred = !z;
      4'd2:  eval_pred = cy;
      4'd3:  eval_pred = !cy;
      4'd4:  eval_pred = n;
      4'd5:  eval_pred = !n;
      4'd6:  eval_pred = v;
      4'd7:  eval_pred = !v;
      4'd8:  eval_pred = cy && !z;
      4'd9:  eval_pred = !cy || z;
      4'd10: eval_pred = (n == v);
      4'd11: eval_pred = (n != v);
      4'd12: eval_pred = !z && (n == v);
      4'd13: eval_pred = z || (n != v);
      4'd14: eval_pred = 1'b1;
      default: eval_pred = 1'b0;
    endcase
  endfunction

  assign pass = eval_pred(cond, flags);
endmodule

// File: rtl/cexu_shift.sv
module cexu_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [1:0]     stype,
  input  logic [SHW-1:0] amt,
  input  logic           c_in,
  output logic [W-1:0]   dout,
  output logic           c_out
);
  import cexu_pkg::*;

  logic [W:0]     left_ext;
  logic [W:0]     right_ext;
  logic [2*W-1:0] rot_dbl;
  logic [W-1:0]   asr_val;

  always_comb begin
    left_ext  = {1'b0, din} << amt;
    right_ext = {din, 1'b0} >> amt;
    rot_dbl   = {din, din} >> amt;
    asr_val   = $unsigned($signed(din) >>> amt);
    unique case (shift_e'(stype))
      SH_LSL: dout = left_ext[W-1:0];
      SH_LSR: dout = right_ext[W:1];
      SH_ASR: dout = asr_val;
      default: dout = rot_dbl[W-1:0];
    endcase
    if (amt == '0)
      c_out = c_in;
    else if (shift_e'(stype) == SH_LSL)
      c_out = left_ext[W];
    else
      c_out = right_ext[0];
  end
endmodule

// File: rtl/cexu_alu.sv
module cexu_alu #(
  parameter int W = 32
) (
  input  logic [1:0]   opsel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sh_carry,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] res,
  output logic [3:0]   flags_calc
);
  import cexu_pkg::*;

  function automatic logic [W:0] add_wide(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic cin);
    add_wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic ovf(input logic sx, input logic sy, input logic sr);
    ovf = (sx == sy) && (sr != sx);
  endfunction

  logic [W:0] sum;
  logic       c_new, v_new;

  always_comb begin
    sum   = '0;
    c_new = sh_carry;
    v_new = flags_in[FLG_V];
    unique case (alu_op_e'(opsel))
      OP_ADD: begin
        sum   = add_wide(a, b, 1'b0);
        res   = sum[W-1:0];
        c_new = sum[W];
        v_new = ovf(a[W-1], b[W-1], res[W-1]);
      end
      OP_SUB: begin
        sum   = add_wide(a, ~b, 1'b1);
        res   = sum[W-1:0];
        c_new = sum[W];
        v_new = ovf(a[W-1], ~b[W-1], res[W-1]);
      end
      OP_AND: res = a & b;
      default: res = b;
    endcase
    flags_calc = '0;
    flags_calc[FLG_N] = res[W-1];
    flags_calc[FLG_Z] = (res == '0);
    flags_calc[FLG_C] = c_new;
    flags_calc[FLG_V] = v_new;
  end
endmodule

// File: rtl/cexec_unit.sv
module cexec_unit #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     cond,
  input  logic [1:0]     opsel,
  input  logic           set_flags,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     shift_type,
  input  logic [SHW-1:0] shift_amt,
  output logic           exec_en,
  output logic [W-1:0]   result,
  output logic           result_we,
  output logic [3:0]     flags_next,
  output logic [3:0]     flags_q
);
  import cexu_pkg::*;

  logic [W-1:0] b_shifted;
  logic         shift_carry;
  logic [3:0]   flags_calc;
  logic         flag_load;

  cexu_cond u_cond (
    .cond  (cond),
    .flags (flags_q),
    .pass  (exec_en)
  );

  cexu_shift #(.W(W)) u_shift (
    .din   (op_b),
    .stype (shift_type),
    .amt   (shift_amt),
    .c_in  (flags_q[FLG_C]),
    .dout  (b_shifted),
    .c_out (shift_carry)
  );

  cexu_alu #(.W(W)) u_alu (
    .opsel      (opsel),
    .a          (op_a),
    .b          (b_shifted),
    .sh_carry   (shift_carry),
    .flags_in   (flags_q),
    .res        (result),
    .flags_calc (flags_calc)
  );

  assign result_we  = exec_en;
  assign flag_load  = exec_en && set_flags;
  assign flags_next = flag_load ? flags_calc : flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_next;
  end
endmodule

// File: rtl/cexec_unit_chk.sv
module cexec_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   cond,
  input logic [1:0]   opsel,
  input logic         set_flags,
  input logic         exec_en,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags_next,
  input logic [3:0]   flags_q
);
  assert_fail_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> (!result_we && flags_next == flags_q));

  assert_eq_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd0 |-> exec_en == flags_q[2]);

  assert_ge_pred_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd10 |-> exec_en == (flags_q[3] == flags_q[0]));

  assert_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd15 |-> !exec_en);

  assert_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd14 |-> (exec_en && result_we));

  assert_noset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |-> flags_next == flags_q);

  assert_reg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flags_q == $past(flags_next));

  assert_logic_keeps_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && set_flags && opsel[1]) |-> flags_next[0] == flags_q[0]);

  assert_nz_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && set_flags) |-> (flags_next[3] == result[W-1] && flags_next[2] == (result == '0)));
endmodule

bind cexec_unit cexec_unit_chk #(.W(W)) u_chk (.*);

// File: tb/cexec_unit_bench.sv
`timescale 1ns/1ps
module cexec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cond = 4'd15;
  logic [1:0]  opsel = '0;
  logic        set_flags = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  shift_type = '0;
  logic [4:0]  shift_amt = '0;
  logic        exec_en, result_we;
  logic [31:0] result;
  logic [3:0]  flags_next, flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        ex;
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [3:0] mflags = 4'h0;

  always #2.5 clk = ~clk;

  cexec_unit u_cexec_unit (.*);

  function automatic logic m_pred(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return z == 1;      1: return z == 0;
      2: return cy == 1;     3: return cy == 0;
      4: return n == 1;      5: return n == 0;
      6: return v == 1;      7: return v == 0;
      8: return cy & ~z;     9: return ~cy | z;
      10: return ~(n ^ v);   11: return n ^ v;
      12: return ~z & ~(n ^ v);
      13: return z | (n ^ v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string pred_tag(input logic [3:0] c);
    if (c < 8) return "R2";
    if (c < 10) return "R3";
    if (c < 14) return "R4";
    return "R5";
  endfunction

  task automatic drive(input logic [3:0] c, input logic [1:0] op, input logic s,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] st, input logic [4:0] sa, input string tag);
    logic [31:0] v;
    logic        cy, ex, nv;
    logic [31:0] r;
    logic [3:0]  nf;
    longint      sl;
    @(negedge clk);
    cond = c; opsel = op; set_flags = s; op_a = a; op_b = b;
    shift_type = st; shift_amt = sa;
    v = b; cy = mflags[1];
    for (int i = 0; i < sa; i++) begin
      case (st)
        0: begin cy = v[31]; v = {v[30:0], 1'b0}; end
        1: begin cy = v[0];  v = {1'b0, v[31:1]}; end
        2: begin cy = v[0];  v = {v[31], v[31:1]}; end
        default: begin cy = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    nv = mflags[0];
    case (op)
      0: begin
        r = a + v; cy = ({32'd0, a} + {32'd0, v}) > 64'hFFFF_FFFF;
        sl = longint'($signed(a)) + longint'($signed(v));
        nv = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      1: begin
        r = a - v; cy = (a >= v);
        sl = longint'($signed(a)) - longint'($signed(v));
        nv = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      2: r = a & v;
      default: r = v;
    endcase
    ex = m_pred(c, mflags);
    nf = (ex && s) ? {r[31], r == 32'd0, cy, nv} : mflags;
    sb.push_back('{ex: ex, res: r, fl: nf, tag: tag});
    mflags = nf;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (exec_en !== e.ex || result_we !== e.ex || flags_q !== e.fl ||
            (e.ex && result !== e.res)) begin
          errors++;
          $display("FAIL %s: ex=%0b we=%0b res=%h flags=%h expected ex=%0b res=%h flags=%h",
                   e.tag, exec_en, result_we, result, flags_q, e.ex, e.res, e.fl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] pa[5] = '{32'd5, 32'd3, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    logic [31:0] pb[5] = '{32'd5, 32'd5, 32'd1, 32'd1, 32'd1};
    logic [1:0]  po[5] = '{2'd1, 2'd1, 2'd0, 2'd1, 2'd0};
    int amts[4] = '{0, 1, 4, 31};
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (flags_q !== 4'h0) begin
      errors++;
      $display("FAIL R12: flags=%h expected 0", flags_q);
    end
    @(negedge clk); rst_n = 1'b1;
    // arithmetic flags: R8 R9 R11
    drive(14, 0, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, "R8");
    drive(14, 0, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, "R8");
    drive(14, 1, 1, 32'd3, 32'd5, 0, 0, "R9");
    drive(14, 1, 1, 32'd5, 32'd5, 0, 0, "R9");
    drive(14, 1, 1, 32'h8000_0000, 32'd1, 0, 0, "R9");
    drive(14, 0, 1, 32'h0000_0010, 32'hFFFF_FFF0, 0, 0, "R11");
    // predicate table under several flag states
    for (int p = 0; p < 5; p++) begin
      drive(14, po[p], 1, pa[p], pb[p], 0, 0, "R8");
      for (int c = 0; c < 16; c++)
        drive(4'(c), 3, 0, 32'd0, 32'hA5A5_0000 + 32'(c), 0, 0, pred_tag(4'(c)));
    end
    // failing predicate with set_flags high: R1
    drive(14, 1, 1, 32'd5, 32'd5, 0, 0, "R9");
    drive(1, 0, 1, 32'd1, 32'd1, 0, 0, "R1");
    drive(15, 1, 1, 32'd0, 32'd7, 0, 0, "R1");
    drive(14, 3, 0, 32'd0, 32'h1234_5678, 0, 0, "R1");
    // executing without set_flags: R7
    drive(14, 0, 0, 32'hFFFF_FFFF, 32'd2, 0, 0, "R7");
    drive(0, 1, 0, 32'd1, 32'd9, 0, 0, "R7");
    // shifter with logical flag update: R6 R10
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 4; k++)
        drive(14, 3, 1, 32'd0, 32'h8000_0011, 2'(t), 5'(amts[k]), "R6");
    drive(14, 0, 1, 32'd1, 32'd3, 0, 2, "R6");
    drive(14, 1, 1, 32'h8000_0000, 32'd1, 0, 0, "R9");
    drive(14, 2, 1, 32'hF0F0_F0F0, 32'h0FF0_0FF1, 0, 0, "R10");
    drive(14, 2, 1, 32'hFFFF_FFFF, 32'h0000_0003, 1, 1, "R10");
    drive(14, 2, 1, 32'h0000_00FF, 32'h0000_0100, 3, 8, "R10");
    drive(14, 3, 1, 32'd0, 32'h0000_0000, 2, 0, "R11");
    @(negedge clk); cond = 4'd15;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule